// File: doc/BRIEF.md
# Peripheral interrupt flag aggregator

This block gathers single-cycle event pulses from motor-control peripherals: a PWM trip, a PWM sync and 24 parallel I/O pins. It records each event in a sticky flag bit and merges all of them onto one active-low, level-style interrupt request for the core interrupt controller. The request stays low while any flag is set in any register.

Service code reads the flags through a small read port. A read returns the contents of the addressed register and clears that register in the same access. The clear is what acknowledges the events. The request rises only after every register holding flags has been read. A combinational dispatch word gives the secondary vector of the highest-priority pending class, so the handler can branch without decoding the flags itself. Trip and sync events pass through enable inputs before they reach their flags.

Top module: `periph_irq_agg`

## Requirements
- R1: After reset all flag bits are clear, `irq_no_o` is 1 and `vec_o` is 0x0000.
- R2: An enabled event sets its flag on the next clock edge. In register 0, bit 0 is trip and bit 1 is sync, and bits 7:2 read as 0. I/O pin k sets bit k%8 of register 1+k/8.
- R3: `irq_no_o` is 0 while any flag bit is set in any of the four registers, and it returns to 1 only when all of them are clear.
- R4: A read of register 0 (`rd_en_i`=1, address 0) returns its current bits on `rd_data_o` in that cycle and clears both trip and sync at the clock edge.
- R5: A read of I/O register n (address 1..3) returns its bits and clears all eight of them. The other registers are left unchanged.
- R6: While `trip_en_i` (or `sync_en_i`) is 0, a trip (or sync) pulse sets no flag.
- R7: `vec_o` is 0x002C when trip is pending, else 0x000C when sync is pending, else 0x0008 when any I/O flag is pending, else 0x0000.
- R8: An event that arrives in the same cycle as a clearing read of its register is set after the clear, so it is not lost.
- R9: Trip and sync pulses in the same cycle are both returned by one read of register 0 (value 0x03).
- R10: With `rd_en_i` at 0, `rd_data_o` shows the addressed register without clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | PWM trip event pulse |
| sync_i | input | 1 | PWM sync event pulse |
| pio_i | input | 24 | I/O pin event pulses |
| trip_en_i | input | 1 | Enable for trip flag setting |
| sync_en_i | input | 1 | Enable for sync flag setting |
| rd_en_i | input | 1 | Read strobe; clears the addressed register |
| rd_addr_i | input | 2 | Register select: 0 status, 1..3 I/O banks |
| rd_data_o | output | 8 | Contents of the addressed register |
| irq_no_o | output | 1 | Merged interrupt request, active low |
| vec_o | output | 16 | Secondary vector of highest pending class |

## Verification
The assertions assume that event inputs are clean, synchronous pulses and that a read strobe is held for exactly one clock per access. They also assume the address is stable while the strobe is high. The stimulus changes every input on the falling edge and never leaves `rd_en_i` high across two edges. Each read therefore clears its register exactly once. The collision case deliberately raises an event in the same cycle as the clearing read of its register.

// File: rtl/periph_irq_pkg.sv
package periph_irq_pkg;
  localparam int unsigned VEC_W     = 16;
  localparam int unsigned BANK_W    = 8;
  localparam int unsigned IO_BANKS  = 3;
  localparam int unsigned ADDR_W    = 2;
  localparam logic [VEC_W-1:0] VEC_TRIP = 16'h002C;
  localparam logic [VEC_W-1:0] VEC_SYNC = 16'h000C;
  localparam logic [VEC_W-1:0] VEC_IO   = 16'h0008;
  localparam logic [VEC_W-1:0] VEC_NONE = 16'h0000;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_IO   = 2'd1,
    CLS_SYNC = 2'd2,
    CLS_TRIP = 2'd3
  } irq_cls_e;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] ev_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;
  logic             past_ok_q;

  // clear first, then merge new events so a colliding event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= '0;
      past_ok_q <= 1'b0;
    end else begin
      flag_q    <= (clr_i ? '0 : flag_q) | ev_i;
      past_ok_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |=> ((flag_q & $past(ev_i)) == $past(ev_i)));

  p_clear_keeps_new_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && clr_i) |=> (flag_q == $past(ev_i)));

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !clr_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc
  import periph_irq_pkg::*;
(
  input  logic             trip_pend_i,
  input  logic             sync_pend_i,
  input  logic             io_pend_i,
  output irq_cls_e         cls_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    if (trip_pend_i)      cls_o = CLS_TRIP;
    else if (sync_pend_i) cls_o = CLS_SYNC;
    else if (io_pend_i)   cls_o = CLS_IO;
    else                  cls_o = CLS_NONE;
  end

  always_comb begin
    unique case (cls_o)
      CLS_TRIP: vec_o = VEC_TRIP;
      CLS_SYNC: vec_o = VEC_SYNC;
      CLS_IO:   vec_o = VEC_IO;
      default:  vec_o = VEC_NONE;
    endcase
  end
endmodule

// File: rtl/periph_irq_agg.sv
module periph_irq_agg
  import periph_irq_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         trip_i,
  input  logic                         sync_i,
  input  logic [IO_BANKS*BANK_W-1:0]   pio_i,
  input  logic                         trip_en_i,
  input  logic                         sync_en_i,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [BANK_W-1:0]            rd_data_o,
  output logic                         irq_no_o,
  output logic [VEC_W-1:0]             vec_o
);
  localparam int unsigned STAT_W = 2;

  logic [STAT_W-1:0] stat_ev, stat_q;
  logic              stat_clr;
  logic [BANK_W-1:0] io_q   [IO_BANKS];
  logic [IO_BANKS-1:0] io_clr, io_any;
  logic              past_ok_q;
  irq_cls_e          cls;

  assign stat_ev  = {sync_i & sync_en_i, trip_i & trip_en_i};
  assign stat_clr = rd_en_i && (rd_addr_i == '0);

  irq_flag_reg #(.WIDTH(STAT_W)) u_stat (
    .clk_i (clk_i), .rst_ni(rst_ni), .ev_i(stat_ev),
    .clr_i (stat_clr), .flag_o(stat_q)
  );

  for (genvar b = 0; b < IO_BANKS; b++) begin : g_bank
    assign io_clr[b] = rd_en_i && (rd_addr_i == ADDR_W'(b + 1));
    irq_flag_reg #(.WIDTH(BANK_W)) u_bank (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .ev_i  (pio_i[b*BANK_W +: BANK_W]),
      .clr_i (io_clr[b]), .flag_o(io_q[b])
    );
    assign io_any[b] = |io_q[b];
  end

  always_comb begin
    rd_data_o = BANK_W'(stat_q);
    for (int b = 0; b < IO_BANKS; b++)
      if (rd_addr_i == ADDR_W'(b + 1)) rd_data_o = io_q[b];
  end

  assign irq_no_o = ~(|stat_q | |io_any);

  irq_vec_enc u_enc (
    .trip_pend_i(stat_q[0]), .sync_pend_i(stat_q[1]), .io_pend_i(|io_any),
    .cls_o(cls), .vec_o(vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_irq_vec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no_o == (vec_o == VEC_NONE));

  p_trip_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[0] |-> (cls == CLS_TRIP));

  p_trip_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !trip_en_i && !stat_clr) |=> (stat_q[0] == $past(stat_q[0])));

  p_sync_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !sync_en_i && !stat_clr) |=> (stat_q[1] == $past(stat_q[1])));

  p_clr_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_clr, stat_clr}));
endmodule

// File: tb/periph_irq_agg_tb.sv
module periph_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trip = 0, sync = 0, trip_en = 1, sync_en = 1, rd_en = 0;
  logic [23:0] pio = '0;
  logic [1:0]  addr = '0;
  logic [7:0]  rd_data;
  logic        irq_n;
  logic [15:0] vec;
  int checks = 0, fails = 0;
  logic [7:0] d;

  always #5 clk = ~clk;

  periph_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trip_i(trip), .sync_i(sync), .pio_i(pio),
    .trip_en_i(trip_en), .sync_en_i(sync_en), .rd_en_i(rd_en),
    .rd_addr_i(addr), .rd_data_o(rd_data), .irq_no_o(irq_n), .vec_o(vec)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic t, input logic s, input logic [23:0] p);
    @(negedge clk); trip = t; sync = s; pio = p;
    @(negedge clk); trip = 0; sync = 0; pio = '0;
    #2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    #2 v = rd_data;
    @(negedge clk); rd_en = 0;
    #2;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #2 v = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 irq", 16'(irq_n), 16'h1);
    chk("R1 vec", vec, 16'h0000);
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), d); chk("R1 reg", 16'(d), 16'h0);
    end
  endtask

  task automatic t_trip;
    pulse(1, 0, '0);
    chk("R3 irq low", 16'(irq_n), 16'h0);
    chk("R7 trip vec", vec, 16'h002C);
    rd(0, d);
    chk("R2 trip bit0", 16'(d), 16'h01);
    chk("R4 cleared irq", 16'(irq_n), 16'h1);
    peek(0, d); chk("R4 reg0 zero", 16'(d), 16'h0);
  endtask

  task automatic t_both;
    pulse(1, 1, '0);
    rd(0, d);
    chk("R9 both bits", 16'(d), 16'h03);
    pulse(0, 1, '0);
    chk("R7 sync vec", vec, 16'h000C);
    rd(0, d);
    chk("R2 sync bit1", 16'(d), 16'h02);
  endtask

  task automatic t_prio;
    pulse(0, 1, 24'h1 << 13);
    chk("R7 sync over io", vec, 16'h000C);
    rd(0, d);
    chk("R7 io vec", vec, 16'h0008);
    chk("R3 still low", 16'(irq_n), 16'h0);
    peek(1, d); chk("R2 bank1 empty", 16'(d), 16'h0);
    rd(2, d);
    chk("R2 pin13", 16'(d), 16'h20);
    chk("R3 released", 16'(irq_n), 16'h1);
    chk("R7 none", vec, 16'h0000);
  endtask

  task automatic t_disabled;
    trip_en = 0; sync_en = 0;
    pulse(1, 1, '0);
    chk("R6 irq high", 16'(irq_n), 16'h1);
    peek(0, d); chk("R6 reg0", 16'(d), 16'h0);
    trip_en = 1; sync_en = 1;
  endtask

  task automatic t_banks;
    pulse(0, 0, 24'h80_0001);
    peek(1, d); chk("R10 peek", 16'(d), 16'h01);
    repeat (3) @(negedge clk);
    peek(1, d); chk("R10 no clear", 16'(d), 16'h01);
    rd(1, d); chk("R5 bank1 read", 16'(d), 16'h01);
    peek(1, d); chk("R5 bank1 clear", 16'(d), 16'h0);
    peek(3, d); chk("R5 bank3 kept", 16'(d), 16'h80);
    chk("R3 low on bank3", 16'(irq_n), 16'h0);
    rd(3, d);
    chk("R3 all clear", 16'(irq_n), 16'h1);
  endtask

  task automatic t_collide;
    pulse(0, 1, '0);
    @(negedge clk); rd_en = 1; addr = 0; trip = 1;
    #2 d = rd_data;
    @(negedge clk); rd_en = 0; trip = 0;
    #2;
    chk("R8 read old", 16'(d), 16'h02);
    peek(0, d); chk("R8 trip kept", 16'(d), 16'h01);
    chk("R8 irq low", 16'(irq_n), 16'h0);
    rd(0, d);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    t_reset();
    t_trip();
    t_both();
    t_prio();
    t_disabled();
    t_banks();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule